// File: doc/BRIEF.md
# Serial Flash Read Engine

This block is the target side of a serial flash interface in clock mode 0, restricted to the two read commands. The select, clock and data-in pins are brought into the system clock domain and oversampled. While select is low, the block shifts in an 8-bit command code and then a 24-bit start address. The fast variant of the command adds one further byte, whose value is discarded. The block then streams bytes from an internal byte-wide array. Each byte goes out most significant bit first, and the address advances after every byte. The stream continues until select goes high. At the top of the array the address returns to zero.

The data-out pin is modelled as a value plus an output enable, and the pad's tri-state buffer sits outside the block. A `busy_i` input tells the block that a program or erase cycle is running. A read command that finishes arriving while `busy_i` is high gets no response. The array has a synchronous load port so that its contents can be set before reads. The serial clock must be slow enough that each half period spans at least six system clocks.

Top module: `sfr_engine`

## Requirements
- R1: After reset, and within four system clocks of select going high, `spi_miso_oe` is 0.
- R2: The command code and the address are taken most significant bit first, on rising serial clock edges. Command code 03h followed by address A returns the array byte at A as the first data byte.
- R3: Command code 0Bh is followed by the address and then one don't-care byte. Only after that byte does the first data byte, the one stored at A, appear.
- R4: Data bits are sent most significant bit first. `spi_miso` changes only after a falling serial clock edge. The first data bit is valid after the falling edge that follows the last address bit (03h) or the last don't-care bit (0Bh).
- R5: Successive data bytes of one command come from addresses A, A+1, A+2 and so on, for as long as the clock keeps running.
- R6: After the byte at address MEM_BYTES-1, the next data byte comes from address 0.
- R7: Address bits above bit log2(MEM_BYTES)-1 are ignored.
- R8: `spi_miso_oe` stays 0 during the command code, address and don't-care bytes.
- R9: Raising select, even in the middle of a byte, ends the command and releases `spi_miso_oe`. The next command is decoded from its first bit. This holds when select rises in the same cycle as a byte-starting falling edge.
- R10: A read command whose eighth code bit arrives while `busy_i` is 1 is ignored. `spi_miso_oe` stays 0 until select rises.
- R11: Any command code other than 03h and 0Bh is ignored until select rises, and `spi_miso_oe` stays 0.
- R12: A cycle with `load_en` high writes `load_data` into the array at `load_addr`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, idles low (mode 0), asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host (value) |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad; 0 means high impedance |
| busy_i | input | 1 | A program or erase cycle is in progress |
| load_en | input | 1 | Array load strobe |
| load_addr | input | log2(MEM_BYTES) | Array load address |
| load_data | input | 8 | Array load data |

## Verification
Two events can collide in a single system cycle: select releasing the command, and the falling edge that starts the next byte. That edge would load the next byte, advance the address and issue a prefetch. The bench provokes the collision by lowering the serial clock and raising select in the same step right after a byte's eighth bit. It then checks that the output enable is released within a few clocks and that no extra byte appears. It also checks that the next command starts cleanly at its own address. A scoreboard compares every received byte against a bench-side model of the array, and any byte that arrives when none is expected counts as a failure.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned SPI_ADDR_BITS = 24;
  localparam int unsigned SPI_BYTE_BITS = 8;

  localparam logic [7:0] CMD_READ      = 8'h03;
  localparam logic [7:0] CMD_READ_FAST = 8'h0B;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_IGNORE = 3'd4
  } sfr_phase_t;

endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic mosi_in,
  output logic cs_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);

  localparam int unsigned LAST = SYNC_STAGES - 1;
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [2:0] chain_q [SYNC_STAGES];
  logic       sck_prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RST_VAL;
          else     chain_q[g] <= {cs_n_in, sck_in, mosi_in};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RST_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_prev_q <= 1'b0;
    else     sck_prev_q <= chain_q[LAST][1];
  end

  assign cs_n_s   = chain_q[LAST][2];
  assign mosi_s   = chain_q[LAST][0];
  assign sck_rise =  chain_q[LAST][1] & ~sck_prev_q;
  assign sck_fall = ~chain_q[LAST][1] &  sck_prev_q;

endmodule

// File: rtl/sfr_array.sv
module sfr_array #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          busy_i,
  input  logic [7:0]    rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          miso_d,
  output logic          miso_oe
);

  localparam logic [4:0] LAST_CMD_BIT  = 5'(SPI_BYTE_BITS - 1);
  localparam logic [4:0] LAST_ADDR_BIT = 5'(SPI_ADDR_BITS - 1);

  sfr_phase_t             phase_q;
  logic [4:0]             bit_cnt_q;
  logic [SPI_ADDR_BITS-2:0] in_sr_q;
  logic                   fast_q;
  logic [AW-1:0]          addr_q;
  logic [7:0]             out_sr_q;
  logic [2:0]             out_idx_q;
  logic                   rd_en_q;
  logic                   miso_d_q;
  logic                   miso_oe_q;

  logic                   active;
  logic [7:0]             opcode_w;
  logic [SPI_ADDR_BITS-1:0] addr_w;
  logic                   launch;
  logic                   cmd_done;

  assign active   = ~cs_n_s;
  assign opcode_w = {in_sr_q[6:0], mosi_s};
  assign addr_w   = {in_sr_q, mosi_s};
  assign cmd_done = active && sck_rise && (phase_q == PH_CMD) && (bit_cnt_q == LAST_CMD_BIT);
  assign launch   = active && sck_fall && (phase_q == PH_DATA) && (out_idx_q == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      in_sr_q   <= '0;
      fast_q    <= 1'b0;
      addr_q    <= '0;
      out_sr_q  <= '0;
      out_idx_q <= '0;
      rd_en_q   <= 1'b0;
      miso_d_q  <= 1'b0;
      miso_oe_q <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      if (!active) begin
        phase_q   <= PH_CMD;
        bit_cnt_q <= '0;
        out_idx_q <= '0;
        miso_oe_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          in_sr_q <= addr_w[SPI_ADDR_BITS-2:0];
          case (phase_q)
            PH_CMD: begin
              if (bit_cnt_q == LAST_CMD_BIT) begin
                bit_cnt_q <= '0;
                if (!busy_i && opcode_w == CMD_READ) begin
                  phase_q <= PH_ADDR;
                  fast_q  <= 1'b0;
                end else if (!busy_i && opcode_w == CMD_READ_FAST) begin
                  phase_q <= PH_ADDR;
                  fast_q  <= 1'b1;
                end else begin
                  phase_q <= PH_IGNORE;
                end
              end else begin
                bit_cnt_q <= bit_cnt_q + 5'd1;
              end
            end
            PH_ADDR: begin
              if (bit_cnt_q == LAST_ADDR_BIT) begin
                bit_cnt_q <= '0;
                addr_q    <= addr_w[AW-1:0];
                if (fast_q) begin
                  phase_q <= PH_DUMMY;
                end else begin
                  phase_q <= PH_DATA;
                  rd_en_q <= 1'b1;
                end
              end else begin
                bit_cnt_q <= bit_cnt_q + 5'd1;
              end
            end
            PH_DUMMY: begin
              if (bit_cnt_q == LAST_CMD_BIT) begin
                bit_cnt_q <= '0;
                phase_q   <= PH_DATA;
                rd_en_q   <= 1'b1;
              end else begin
                bit_cnt_q <= bit_cnt_q + 5'd1;
              end
            end
            default: ;
          endcase
        end
        if (sck_fall && phase_q == PH_DATA) begin
          miso_oe_q <= 1'b1;
          out_idx_q <= out_idx_q + 3'd1;
          if (out_idx_q == 3'd0) begin
            miso_d_q <= rd_data[7];
            out_sr_q <= {rd_data[6:0], 1'b0};
            addr_q   <= addr_q + 1'b1;
            rd_en_q  <= 1'b1;
          end else begin
            miso_d_q <= out_sr_q[7];
            out_sr_q <= {out_sr_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_en   = rd_en_q;
  assign rd_addr = addr_q;
  assign miso_d  = miso_d_q;
  assign miso_oe = miso_oe_q;

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe_q) else $error("oe held with select high"); // R1

  AST_HIZ_HEADER: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_DATA) |-> !miso_oe_q) else $error("oe during header"); // R8

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && busy_i) |=> (phase_q == PH_IGNORE)) else $error("read accepted while busy"); // R10

  AST_IGNORE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IGNORE && active) |=> (phase_q == PH_IGNORE)) else $error("left ignore state"); // R11

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !(sck_fall && active) |=> $stable(miso_d_q)) else $error("miso moved without falling edge"); // R4

  AST_FETCH_BEFORE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> !launch) else $error("byte launched before fetch returned"); // R5

endmodule

// File: rtl/sfr_engine.sv
module sfr_engine #(
  parameter int unsigned MEM_BYTES   = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          busy_i,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data
);

  logic          cs_n_s;
  logic          sck_rise;
  logic          sck_fall;
  logic          mosi_s;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  sfr_pin_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .cs_n_in (spi_cs_n),
    .sck_in  (spi_sck),
    .mosi_in (spi_mosi),
    .cs_n_s  (cs_n_s),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (mosi_s)
  );

  sfr_array #(
    .DEPTH(MEM_BYTES),
    .DW   (8)
  ) u_array (
    .clk    (clk),
    .wr_en  (load_en),
    .wr_addr(load_addr),
    .wr_data(load_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  sfr_ctrl #(
    .AW(AW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs_n_s  (cs_n_s),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (mosi_s),
    .busy_i  (busy_i),
    .rd_data (rd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .miso_d  (spi_miso),
    .miso_oe (spi_miso_oe)
  );

endmodule

// File: tb/sfr_engine_tb.sv
module sfr_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 1024;
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int HALF_CLKS  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_cs_n = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_mosi = 1'b0;
  logic          spi_miso;
  logic          spi_miso_oe;
  logic          busy_i = 1'b0;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0]    load_data = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [MEM_BYTES];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfr_engine #(.MEM_BYTES(MEM_BYTES)) u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .busy_i(busy_i), .load_en(load_en), .load_addr(load_addr), .load_data(load_data)
  );

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: assembles bytes at host sampling edges and pops the scoreboard.
  logic [7:0] mon_byte = '0;
  int         mon_bits = 0;
  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      mon_bits = 0;
    end else if (spi_miso_oe) begin
      mon_byte = {mon_byte[6:0], spi_miso};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected byte", int'(mon_byte), 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(mon_byte == e, t, int'(mon_byte), int'(e));
        end
      end
    end
  end

  // One host bit: set data, rising edge, falling edge. Returns oe seen at the rise.
  task automatic host_bit(input logic b, input bit merge_end, output logic oe_seen);
    spi_mosi = b;
    wait_clks(HALF_CLKS);
    spi_sck = 1'b1;
    oe_seen = spi_miso_oe;
    wait_clks(HALF_CLKS);
    spi_sck = 1'b0;
    if (merge_end) spi_cs_n = 1'b1;
  endtask

  task automatic host_byte(input logic [7:0] b, input bit merge_end, output logic any_oe);
    logic o;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      host_bit(b[i], merge_end && (i == 0), o);
      any_oe |= o;
    end
  endtask

  task automatic load(input int a, input logic [7:0] d);
    load_en = 1'b1; load_addr = AW'(a); load_data = d;
    wait_clks(1);
    load_en = 1'b0;
    model[a] = d;
  endtask

  // Driver: sends a read, pushes expected bytes, clocks data, ends command.
  task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                         input bit expect_data, input bit merge_end, input string req);
    logic hdr_oe, o, tot;
    int   a;
    a = int'(addr[AW-1:0]);
    if (expect_data) begin
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(model[(a + k) % MEM_BYTES]);
        tag_q.push_back(req);
      end
    end
    spi_cs_n = 1'b0;
    wait_clks(HALF_CLKS);
    hdr_oe = 1'b0;
    host_byte(op, 1'b0, o);          hdr_oe |= o;
    host_byte(addr[23:16], 1'b0, o); hdr_oe |= o;
    host_byte(addr[15:8], 1'b0, o);  hdr_oe |= o;
    host_byte(addr[7:0], 1'b0, o);   hdr_oe |= o;
    if (op == 8'h0B) begin
      host_byte(8'hA5, 1'b0, o);     hdr_oe |= o;
    end
    check(!hdr_oe, "R8 oe during header", int'(hdr_oe), 0);
    tot = 1'b0;
    for (int k = 0; k < nbytes; k++) begin
      host_byte(8'h00, merge_end && (k == nbytes - 1), o);
      tot |= o;
    end
    if (!expect_data) check(!tot, {req, " oe during ignored command"}, int'(tot), 0);
    if (!merge_end) begin
      wait_clks(HALF_CLKS);
      spi_cs_n = 1'b1;
    end
    wait_clks(4);
    check(!spi_miso_oe, "R1 oe after select high", int'(spi_miso_oe), 0);
    wait_clks(HALF_CLKS);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic o;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(2);
    check(!spi_miso_oe, "R1 reset oe", int'(spi_miso_oe), 0);

    for (int i = 0; i < MEM_BYTES; i++) load(i, pattern(i));   // R12 preload
    wait_clks(2);

    do_read(8'h03, 24'h000010, 4, 1'b1, 1'b0, "R2 R5 read");
    do_read(8'h0B, 24'h000200, 3, 1'b1, 1'b0, "R3 fast read");
    do_read(8'h03, 24'(MEM_BYTES - 2), 4, 1'b1, 1'b0, "R6 wrap");
    do_read(8'h0B, 24'(MEM_BYTES - 1), 2, 1'b1, 1'b0, "R6 fast wrap");
    do_read(8'h03, 24'hF00005, 2, 1'b1, 1'b0, "R7 upper bits");
    do_read(8'h03, 24'h0001A3, 3, 1'b1, 1'b0, "R4 msb first");

    load(24'h060, 8'h5A);                                      // R12 overwrite
    do_read(8'h03, 24'h000060, 1, 1'b1, 1'b0, "R12 load");

    busy_i = 1'b1;
    do_read(8'h03, 24'h000010, 3, 1'b0, 1'b0, "R10 busy");
    do_read(8'h0B, 24'h000010, 3, 1'b0, 1'b0, "R10 busy fast");
    busy_i = 1'b0;

    do_read(8'h05, 24'h000010, 3, 1'b0, 1'b0, "R11 other opcode");

    // R9: select rises mid-byte.
    exp_q.push_back(model[24'h30]); tag_q.push_back("R9 abort first byte");
    spi_cs_n = 1'b0;
    wait_clks(HALF_CLKS);
    host_byte(8'h03, 1'b0, o);
    host_byte(8'h00, 1'b0, o);
    host_byte(8'h00, 1'b0, o);
    host_byte(8'h30, 1'b0, o);
    host_byte(8'h00, 1'b0, o);
    for (int i = 0; i < 3; i++) host_bit(1'b0, 1'b0, o);
    spi_cs_n = 1'b1;
    wait_clks(4);
    check(!spi_miso_oe, "R9 oe after mid-byte abort", int'(spi_miso_oe), 0);
    wait_clks(HALF_CLKS);
    do_read(8'h03, 24'h000040, 2, 1'b1, 1'b0, "R9 after abort");

    // R9: select rises in the same step as the byte-starting falling edge.
    do_read(8'h03, 24'h000050, 2, 1'b1, 1'b1, "R9 merged end");
    do_read(8'h0B, 24'h000077, 2, 1'b1, 1'b0, "R9 after merged end");

    wait_clks(10);
    check(exp_q.size() == 0, "R5 missing bytes", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule